// File: doc/BRIEF.md
# Tone Receiver Register Bus Interface

This block sits between a small microprocessor and the detection and generation logic of a dual-tone receiver/transmitter. The processor reaches it over a 4-bit data bus with active-low chip select, read and write strobes and one register-select line. The bus gives access to five registers. With select low, a write loads the transmit tone code and a read returns the received tone code. With select high, a write goes to one of two control registers that share that address, and a read returns a status word.

The receive side latches a 4-bit tone code on each rising edge of the delayed-steering flag from the detector. It holds a ready bit until software reads the status word. One open-drain interrupt pin serves two purposes. It normally signals a pending received code. When the call-progress filter is selected, it instead passes on the limited comparator square wave.

The strobes are sampled on the system clock. A write commits once, in the first clock cycle in which chip select and write are both low. The data bus is split into `data_in`, `data_out` and an output enable, and the tri-state buffer sits outside this block.

Top module: `tone_bus_regs`

## Requirements
- R1: After synchronous reset, all control bits are 0, the transmit code is 0, the ready bit is clear, `irq_pull` is 0 and `data_oe` is 0.
- R2: `data_oe` is 1 exactly while `cs_n` and `rd_n` are both 0. While it is 0, `data_out` is all zeros.
- R3: A register changes only when `cs_n` and `wr_n` are both low. Each strobe commits once, in its first active cycle, even if the strobe is held longer. A strobe given with `cs_n` high changes nothing.
- R4: A write with `rsel`=0 loads `tx_code` from `data_in` on the commit edge. `tx_load` is then 1 for exactly the one following cycle. A read with `rsel`=0 returns the latched receive code.
- R5: On a rising edge of `rx_valid`, the design latches `rx_code` and sets the ready bit. The code is not relatched while `rx_valid` stays high or after it falls.
- R6: A write with `rsel`=1 to the first control register sets four fields: bit 0 tone output enable (`ctl_tone_en`), bit 1 call-progress mode (`ctl_cp_mode`), bit 2 interrupt enable (`ctl_irq_en`), and bit 3, which redirects the next control write.
- R7: While bit 3 of the first control register is set, the next control write loads the second control register (`ctl_ext`) instead. The first register's other fields are kept, and its bit 3 clears, so the following control write reaches the first register again.
- R8: A read with `rsel`=1 returns the status word. Bit 0 is the ready bit. Bit 1 is 1 when ready is set, interrupts are enabled and call-progress mode is off. Bits 3:2 are 0. The ready bit clears in the cycle after a status read strobe is released. A new rising edge of `rx_valid` in that same cycle leaves it set.
- R9: With interrupts enabled and call-progress mode off, `irq_pull` equals the ready bit.
- R10: With interrupts enabled and call-progress mode on, `irq_pull` is the inverse of `cp_square`, so the pin goes low while the square wave is low. With interrupts disabled, `irq_pull` is 0 in either mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| cs_n | input | 1 | Chip select, active low |
| rd_n | input | 1 | Read strobe, active low |
| wr_n | input | 1 | Write strobe, active low |
| rsel | input | 1 | Register select: 0 data, 1 control/status |
| data_in | input | DW | Write data from the bus |
| data_out | output | DW | Read data to the bus |
| data_oe | output | 1 | Bus drive enable |
| rx_valid | input | 1 | Delayed-steering flag from the detector |
| rx_code | input | DW | Decoded tone code from the detector |
| cp_square | input | 1 | Limited call-progress comparator output |
| irq_pull | output | 1 | Pull interrupt pin low (open-drain drive) |
| ctl_tone_en | output | 1 | Tone output enable |
| ctl_cp_mode | output | 1 | Call-progress filter select |
| ctl_irq_en | output | 1 | Interrupt enable |
| ctl_ext | output | DW | Second control register contents |
| tx_code | output | DW | Transmit tone code |
| tx_load | output | 1 | One-cycle pulse after a transmit code write |

## Verification
The bench builds the block with its default width of four bits, the same width as the real bus. This makes every status, control and code field match the bit positions stated in the requirements. At this width, the control address and its redirect bit can be exercised in full. The bench can also line up a status-read release and a new steering edge in the same cycle, and hold strobes over several cycles to show that each strobe commits only once.

// File: rtl/tbus_pkg.sv
package tbus_pkg;

    // First control register layout; bit positions are decoded by software.
    typedef struct packed {
        logic sel_b;    // bit 3: redirect next control write
        logic irq_en;   // bit 2
        logic cp_mode;  // bit 1
        logic tone_en;  // bit 0
    } ctrl_a_t;

    localparam int STAT_READY_BIT = 0;
    localparam int STAT_IRQ_BIT   = 1;

    // Interrupt request latched view (not the call-progress passthrough).
    function automatic logic irq_request(input ctrl_a_t c, input logic ready);
        return ready & c.irq_en & ~c.cp_mode;
    endfunction

    // Open-drain pull decision for the shared interrupt pin.
    function automatic logic irq_drive(input ctrl_a_t c, input logic ready,
                                       input logic square);
        if (!c.irq_en)
            return 1'b0;
        return c.cp_mode ? ~square : ready;
    endfunction

endpackage

// File: rtl/tbus_strobe.sv
module tbus_strobe (
    input  logic clk,
    input  logic rst,
    input  logic cs_n,
    input  logic rd_n,
    input  logic wr_n,
    input  logic rsel,
    output logic wr_pulse,
    output logic rd_act,
    output logic stat_done
);
    logic wr_act;
    logic wr_q;
    logic rd_q;
    logic rsel_q;

    assign wr_act = ~cs_n & ~wr_n;
    assign rd_act = ~cs_n & ~rd_n;

    always_ff @(posedge clk) begin
        if (rst) begin
            wr_q   <= 1'b0;
            rd_q   <= 1'b0;
            rsel_q <= 1'b0;
        end else begin
            wr_q <= wr_act;
            rd_q <= rd_act;
            if (rd_act)
                rsel_q <= rsel;
        end
    end

    assign wr_pulse  = wr_act & ~wr_q;
    assign stat_done = rd_q & ~rd_act & rsel_q;

    // R3
    wr_once_chk: assert property (@(posedge clk) disable iff (rst)
        wr_pulse |=> !wr_pulse);

endmodule

// File: rtl/tbus_ctrl.sv
module tbus_ctrl
    import tbus_pkg::*;
#(
    parameter int DW = 4
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          wr_pulse,
    input  logic          rsel,
    input  logic [DW-1:0] din,
    output ctrl_a_t       ctrl_a,
    output logic [DW-1:0] ctrl_b,
    output logic [DW-1:0] tx_code,
    output logic          tx_load
);
    always_ff @(posedge clk) begin
        if (rst) begin
            ctrl_a  <= '0;
            ctrl_b  <= '0;
            tx_code <= '0;
            tx_load <= 1'b0;
        end else begin
            tx_load <= 1'b0;
            if (wr_pulse) begin
                if (!rsel) begin
                    tx_code <= din;
                    tx_load <= 1'b1;
                end else if (ctrl_a.sel_b) begin
                    ctrl_b       <= din;
                    ctrl_a.sel_b <= 1'b0;
                end else begin
                    ctrl_a <= ctrl_a_t'(din[3:0]);
                end
            end
        end
    end

    // R7
    redirect_clear_chk: assert property (@(posedge clk) disable iff (rst)
        (wr_pulse && rsel && ctrl_a.sel_b) |=> !ctrl_a.sel_b);

    // R4
    tx_pulse_chk: assert property (@(posedge clk) disable iff (rst)
        tx_load |=> !tx_load);

endmodule

// File: rtl/tbus_rx.sv
module tbus_rx #(
    parameter int DW = 4
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          rx_valid,
    input  logic [DW-1:0] rx_code,
    input  logic          stat_clr,
    output logic [DW-1:0] rx_data,
    output logic          rx_ready
);
    logic rv_q;
    logic rise;

    assign rise = rx_valid & ~rv_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            rv_q     <= 1'b0;
            rx_data  <= '0;
            rx_ready <= 1'b0;
        end else begin
            rv_q <= rx_valid;
            if (rise) begin
                rx_data  <= rx_code;
                rx_ready <= 1'b1;
            end else if (stat_clr) begin
                rx_ready <= 1'b0;
            end
        end
    end

    // R5
    rx_latch_chk: assert property (@(posedge clk) disable iff (rst)
        rise |=> (rx_ready && rx_data == $past(rx_code)));

    // R8
    ready_clear_chk: assert property (@(posedge clk) disable iff (rst)
        (stat_clr && !rise) |=> !rx_ready);

endmodule

// File: rtl/tone_bus_regs.sv
module tone_bus_regs
    import tbus_pkg::*;
#(
    parameter int DW = 4
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          cs_n,
    input  logic          rd_n,
    input  logic          wr_n,
    input  logic          rsel,
    input  logic [DW-1:0] data_in,
    output logic [DW-1:0] data_out,
    output logic          data_oe,
    input  logic          rx_valid,
    input  logic [DW-1:0] rx_code,
    input  logic          cp_square,
    output logic          irq_pull,
    output logic          ctl_tone_en,
    output logic          ctl_cp_mode,
    output logic          ctl_irq_en,
    output logic [DW-1:0] ctl_ext,
    output logic [DW-1:0] tx_code,
    output logic          tx_load
);
    logic          wr_pulse;
    logic          rd_act;
    logic          stat_done;
    ctrl_a_t       ctrl_a;
    logic [DW-1:0] rx_data;
    logic          rx_ready;
    logic [DW-1:0] status_w;

    tbus_strobe u_strobe (
        .clk       (clk),
        .rst       (rst),
        .cs_n      (cs_n),
        .rd_n      (rd_n),
        .wr_n      (wr_n),
        .rsel      (rsel),
        .wr_pulse  (wr_pulse),
        .rd_act    (rd_act),
        .stat_done (stat_done)
    );

    tbus_ctrl #(.DW(DW)) u_ctrl (
        .clk      (clk),
        .rst      (rst),
        .wr_pulse (wr_pulse),
        .rsel     (rsel),
        .din      (data_in),
        .ctrl_a   (ctrl_a),
        .ctrl_b   (ctl_ext),
        .tx_code  (tx_code),
        .tx_load  (tx_load)
    );

    tbus_rx #(.DW(DW)) u_rx (
        .clk      (clk),
        .rst      (rst),
        .rx_valid (rx_valid),
        .rx_code  (rx_code),
        .stat_clr (stat_done),
        .rx_data  (rx_data),
        .rx_ready (rx_ready)
    );

    always_comb begin
        status_w                 = '0;
        status_w[STAT_READY_BIT] = rx_ready;
        status_w[STAT_IRQ_BIT]   = irq_request(ctrl_a, rx_ready);
    end

    assign data_oe  = rd_act;
    assign data_out = rd_act ? (rsel ? status_w : rx_data) : '0;
    assign irq_pull = irq_drive(ctrl_a, rx_ready, cp_square);

    assign ctl_tone_en = ctrl_a.tone_en;
    assign ctl_cp_mode = ctrl_a.cp_mode;
    assign ctl_irq_en  = ctrl_a.irq_en;

    // R9
    irq_source_chk: assert property (@(posedge clk) disable iff (rst)
        (irq_pull && !ctl_cp_mode) |-> rx_ready);

    // R3
    no_select_write_chk: assert property (@(posedge clk) disable iff (rst)
        cs_n |=> ($stable(tx_code) && $stable(ctl_ext)));

    // R10
    irq_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        !ctl_irq_en |-> !irq_pull);

endmodule

// File: tb/tone_bus_regs_bench.sv
module tone_bus_regs_bench;
    localparam int DW = 4;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          cs_n = 1'b1, rd_n = 1'b1, wr_n = 1'b1, rsel = 1'b0;
    logic [DW-1:0] data_in = '0;
    logic [DW-1:0] data_out;
    logic          data_oe;
    logic          rx_valid = 1'b0;
    logic [DW-1:0] rx_code = '0;
    logic          cp_square = 1'b0;
    logic          irq_pull;
    logic          ctl_tone_en, ctl_cp_mode, ctl_irq_en;
    logic [DW-1:0] ctl_ext, tx_code;
    logic          tx_load;

    int n_checks = 0;
    int n_err = 0;
    int cycles = 0;

    always #4 clk = ~clk;

    tone_bus_regs #(.DW(DW)) u_tone_bus_regs (
        .clk(clk), .rst(rst), .cs_n(cs_n), .rd_n(rd_n), .wr_n(wr_n),
        .rsel(rsel), .data_in(data_in), .data_out(data_out),
        .data_oe(data_oe), .rx_valid(rx_valid), .rx_code(rx_code),
        .cp_square(cp_square), .irq_pull(irq_pull),
        .ctl_tone_en(ctl_tone_en), .ctl_cp_mode(ctl_cp_mode),
        .ctl_irq_en(ctl_irq_en), .ctl_ext(ctl_ext), .tx_code(tx_code),
        .tx_load(tx_load)
    );

    // Behavioural reference state
    int m_tone, m_cp, m_irq, m_redir, m_ext, m_tx, m_txl;
    int m_rx, m_rdy, m_wrq, m_rdq, m_rselq, m_rvq;

    task automatic model_reset();
        m_tone = 0; m_cp = 0; m_irq = 0; m_redir = 0; m_ext = 0;
        m_tx = 0; m_txl = 0; m_rx = 0; m_rdy = 0;
        m_wrq = 0; m_rdq = 0; m_rselq = 0; m_rvq = 0;
    endtask

    task automatic chk(string tag, string what, int act, int exp);
        n_checks++;
        if (act != exp) begin
            n_err++;
            $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, exp);
        end
    endtask

    task automatic step(string tag, bit cs, bit rd, bit wr, bit rs,
                        int din, bit rxv, int rxc, bit sq);
        int rd_act, wr_act, oe, dout, pull, wp, re, rise;
        @(negedge clk);
        cs_n = cs; rd_n = rd; wr_n = wr; rsel = rs;
        data_in = DW'(din); rx_valid = rxv; rx_code = DW'(rxc); cp_square = sq;
        #1;
        if (!rst) begin
            rd_act = (!cs && !rd) ? 1 : 0;
            oe = rd_act;
            if (!oe) dout = 0;
            else if (rs) dout = m_rdy + 2 * ((m_rdy && m_irq && !m_cp) ? 1 : 0);
            else dout = m_rx;
            if (!m_irq) pull = 0;
            else if (m_cp) pull = sq ? 0 : 1;
            else pull = m_rdy;
            chk(tag, "data_oe", int'(data_oe), oe);
            chk(tag, "data_out", int'(data_out), dout);
            chk(tag, "irq_pull", int'(irq_pull), pull);
            chk(tag, "tone_en", int'(ctl_tone_en), m_tone);
            chk(tag, "cp_mode", int'(ctl_cp_mode), m_cp);
            chk(tag, "irq_en", int'(ctl_irq_en), m_irq);
            chk(tag, "ctl_ext", int'(ctl_ext), m_ext);
            chk(tag, "tx_code", int'(tx_code), m_tx);
            chk(tag, "tx_load", int'(tx_load), m_txl);
        end
        @(posedge clk);
        if (rst) begin
            model_reset();
        end else begin
            wr_act = (!cs && !wr) ? 1 : 0;
            rd_act = (!cs && !rd) ? 1 : 0;
            wp = (wr_act && !m_wrq) ? 1 : 0;
            re = (m_rdq && !rd_act && m_rselq) ? 1 : 0;
            rise = (rxv && !m_rvq) ? 1 : 0;
            m_txl = (wp && !rs) ? 1 : 0;
            if (wp) begin
                if (!rs) m_tx = din;
                else if (m_redir) begin m_ext = din; m_redir = 0; end
                else begin
                    m_tone = din & 1; m_cp = (din >> 1) & 1;
                    m_irq = (din >> 2) & 1; m_redir = (din >> 3) & 1;
                end
            end
            if (rise) begin m_rdy = 1; m_rx = rxc; end
            else if (re) m_rdy = 0;
            m_wrq = wr_act; m_rdq = rd_act;
            if (rd_act) m_rselq = rs;
            m_rvq = rxv;
        end
    endtask

    // idle helper
    task automatic idle(string tag, int n);
        for (int i = 0; i < n; i++) step(tag, 1, 1, 1, 0, 0, rx_valid, int'(rx_code), cp_square);
    endtask

    initial begin
        forever begin
            @(posedge clk);
            cycles++;
            if (cycles > 20000) begin
                n_err++;
                $display("FAIL R1 watchdog actual=%0d expected=done", cycles);
                $display("CHECKS %0d ERRORS %0d", n_checks, n_err);
                $finish;
            end
        end
    end

    initial begin
        model_reset();
        step("R1", 1, 1, 1, 0, 0, 0, 0, 0);
        step("R1", 1, 1, 1, 0, 0, 0, 0, 0);
        rst = 1'b0;
        // R1: reset state checked at ports
        step("R1", 1, 1, 1, 0, 0, 0, 0, 0);
        chk("R1", "data_oe_reset", int'(data_oe), 0);
        chk("R1", "irq_reset", int'(irq_pull), 0);
        // R2: read strobe without chip select
        step("R2", 1, 0, 1, 0, 0, 0, 0, 0);
        step("R2", 1, 0, 1, 1, 0, 0, 0, 0);
        // R3: write without chip select leaves state unchanged
        step("R3", 1, 1, 0, 0, 4'hA, 0, 0, 0);
        step("R3", 1, 1, 0, 1, 4'hF, 0, 0, 0);
        step("R3", 1, 1, 1, 0, 0, 0, 0, 0);
        // R4: data write held 3 cycles commits once
        step("R4", 0, 1, 0, 0, 5, 0, 0, 0);
        step("R4", 0, 1, 0, 0, 6, 0, 0, 0);
        step("R4", 0, 1, 0, 0, 7, 0, 0, 0);
        step("R4", 1, 1, 1, 0, 0, 0, 0, 0);
        // R5: steering edge latches code; changes while high ignored
        step("R5", 1, 1, 1, 0, 0, 1, 9, 0);
        step("R5", 1, 1, 1, 0, 0, 1, 3, 0);
        step("R5", 1, 1, 1, 0, 0, 0, 12, 0);
        step("R5", 0, 0, 1, 0, 0, 0, 12, 0);
        step("R4", 0, 0, 1, 0, 0, 0, 12, 0);
        step("R5", 1, 1, 1, 0, 0, 0, 12, 0);
        // R6: control write tone+irq
        step("R6", 0, 1, 0, 1, 4'b0101, 0, 0, 0);
        step("R9", 1, 1, 1, 0, 0, 0, 0, 0);
        // R8: status read, clear on release
        step("R8", 0, 0, 1, 1, 0, 0, 0, 0);
        step("R8", 0, 0, 1, 1, 0, 0, 0, 0);
        step("R8", 1, 1, 1, 0, 0, 0, 0, 0);
        step("R9", 1, 1, 1, 0, 0, 0, 0, 0);
        // R8: release coincides with new steering edge -> ready stays
        step("R8", 1, 1, 1, 0, 0, 1, 2, 0);
        step("R8", 0, 0, 1, 1, 0, 0, 2, 0);
        step("R8", 1, 1, 1, 0, 0, 1, 11, 0);
        step("R8", 1, 1, 1, 0, 0, 1, 11, 0);
        step("R8", 0, 0, 1, 0, 0, 1, 11, 0);
        step("R8", 0, 0, 1, 1, 0, 0, 11, 0);
        step("R8", 1, 1, 1, 0, 0, 0, 11, 0);
        // R7: redirect to second control register
        step("R7", 0, 1, 0, 1, 4'b1100, 0, 0, 0);
        step("R7", 1, 1, 1, 0, 0, 0, 0, 0);
        step("R7", 0, 1, 0, 1, 4'b1010, 0, 0, 0);
        step("R7", 1, 1, 1, 0, 0, 0, 0, 0);
        step("R7", 0, 1, 0, 1, 4'b0001, 0, 0, 0);
        step("R7", 1, 1, 1, 0, 0, 0, 0, 0);
        // R10: call-progress passthrough with interrupts enabled
        step("R10", 0, 1, 0, 1, 4'b0110, 1, 5, 0);
        step("R10", 1, 1, 1, 0, 0, 1, 5, 1);
        step("R10", 1, 1, 1, 0, 0, 1, 5, 0);
        step("R10", 1, 1, 1, 0, 0, 0, 5, 1);
        step("R8", 0, 0, 1, 1, 0, 0, 5, 1);
        step("R10", 1, 1, 1, 0, 0, 0, 5, 0);
        // R10: call-progress without interrupts -> released
        step("R10", 0, 1, 0, 1, 4'b0010, 0, 5, 0);
        step("R10", 1, 1, 1, 0, 0, 0, 5, 1);
        step("R10", 1, 1, 1, 0, 0, 0, 5, 0);
        // R9: back to interrupt mode with ready pending
        step("R9", 0, 1, 0, 1, 4'b0100, 1, 8, 0);
        step("R9", 1, 1, 1, 0, 0, 1, 8, 0);
        idle("R9", 2);
        $display("CHECKS %0d ERRORS %0d", n_checks, n_err);
        $finish;
    end
endmodule